// File: doc/BRIEF.md
# Single-Precision Register Format Converter

This block moves single-precision floating-point values between their 32-bit memory form and a 64-bit register form that holds an 11-bit exponent field. When a value is loaded, the 8-bit exponent is widened by a rule that is not a plain bit move. The rule keeps zero at zero and keeps the all-ones code, which marks infinity or NaN, at all-ones. Every finite exponent is re-biased so that the register value reads as a double-precision number of the same magnitude. When a value is stored, the register form is folded back into 32 bits by picking out fixed bit groups.

A third path packs a 32-bit integer into the same register bit positions. It raises two flags, overflow and inexact, when the 64-bit source value does not fit in a signed 32-bit integer. The block is purely combinational. A 2-bit mode input picks the path, and every path shares one 64-bit data input and one 64-bit data output. The block does no arithmetic on the values.

Top module: `sp_regfmt_conv`

## Requirements
- R1: In load mode (mode 2'b00), the output takes memory bit 31 at bit 63 and memory bits 22:0 at bits 51:29. Output bits 28:0 are zero, and input bits 63:32 have no effect.
- R2: In load mode, when memory exponent bit 30 is 1 and bits 29:23 are not all ones, the 11-bit output exponent (bits 62:52) is {1, 3'b000, bits 29:23}.
- R3: In load mode, a memory exponent of 8'hFF gives the output exponent 11'h7FF.
- R4: In load mode, when memory exponent bit 30 is 0 and bits 29:23 are nonzero, the output exponent is {0, 3'b111, bits 29:23}.
- R5: In load mode, a memory exponent of zero gives an output exponent of zero.
- R6: In store mode (mode 2'b01), output bits 31:30 take input bits 63:62 and output bits 29:0 take input bits 58:29. Output bits 63:32 are zero.
- R7: In longword-pack mode (mode 2'b10), output bits 63:62 take input bits 31:30 and output bits 58:29 take input bits 29:0. All other output bits are zero.
- R8: In longword-pack mode, the overflow and inexact flags are both 1 exactly when the 64-bit input differs from the sign extension of its low 32 bits. Otherwise both are 0.
- R9: In load and store modes, both flags are 0.
- R10: Mode 2'b11 gives an all-zero output and both flags 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_sel | input | 2 | Path select: 00 load, 01 store, 10 longword pack, 11 idle |
| data_in | input | 64 | Memory image in bits 31:0, register image, or 64-bit integer |
| data_out | output | 64 | Converted result |
| ovf_flag | output | 1 | Integer overflow from longword packing |
| inexact_flag | output | 1 | Inexact from longword packing |

## Verification
The checker takes for granted that mode_sel and data_in are stable, known values whenever the outputs are evaluated. The bench meets this by changing the inputs one time unit after a rising clock edge and comparing on the falling edge. Random vectors cover every mode code and leave the unused upper input bits random in load mode. Longword-pack inputs are biased so that about half of them fit in a signed 32-bit integer. Directed vectors add exponent codes 0x00, 0x7F, 0x80, 0xFE and 0xFF, and the integer edges ±2^31.

// File: rtl/sp_regfmt_pkg.sv
package sp_regfmt_pkg;

    localparam int MEM_W   = 32;
    localparam int REG_W   = 64;
    localparam int SEXP_W  = 8;
    localparam int DEXP_W  = 11;
    localparam int FRAC_W  = MEM_W - 1 - SEXP_W;
    localparam int PAD_W   = REG_W - 1 - DEXP_W - FRAC_W;
    localparam int LOW_W   = SEXP_W - 1;
    localparam int GAP_W   = DEXP_W - SEXP_W;
    localparam int LW_HI_W = 2;
    localparam int LW_LO_W = MEM_W - LW_HI_W;

    typedef enum logic [1:0] {
        CONV_LOAD   = 2'b00,
        CONV_STORE  = 2'b01,
        CONV_LWPACK = 2'b10,
        CONV_IDLE   = 2'b11
    } conv_mode_e;

    typedef struct packed {
        logic              sign;
        logic [SEXP_W-1:0] exp;
        logic [FRAC_W-1:0] frac;
    } mem_img_t;

    typedef struct packed {
        logic              sign;
        logic [DEXP_W-1:0] exp;
        logic [FRAC_W-1:0] frac;
        logic [PAD_W-1:0]  pad;
    } reg_img_t;

    typedef struct packed {
        logic ovf;
        logic inexact;
    } conv_flags_t;

    // Widen a narrow exponent while keeping the zero and all-ones codes.
    function automatic logic [DEXP_W-1:0] widen_exp(input logic [SEXP_W-1:0] e);
        logic             top;
        logic [LOW_W-1:0] low;
        logic [DEXP_W-1:0] w;
        top = e[SEXP_W-1];
        low = e[LOW_W-1:0];
        w   = {top, {GAP_W{1'b0}}, low};
        if (top && (&low)) begin
            w = '1;
        end else if (!top && (|low)) begin
            w[DEXP_W-2 -: GAP_W] = '1;
        end
        return w;
    endfunction

endpackage

// File: rtl/sp_expand.sv
module sp_expand
    import sp_regfmt_pkg::*;
(
    input  logic [MEM_W-1:0] mem_word,
    output logic [REG_W-1:0] reg_word
);
    mem_img_t m;
    reg_img_t r;

    always_comb begin
        m      = mem_img_t'(mem_word);
        r.sign = m.sign;
        r.exp  = widen_exp(m.exp);
        r.frac = m.frac;
        r.pad  = '0;
    end

    assign reg_word = REG_W'(r);
endmodule

// File: rtl/sp_compress.sv
module sp_compress
    import sp_regfmt_pkg::*;
(
    input  logic [REG_W-1:0] reg_word,
    output logic [MEM_W-1:0] mem_word
);
    reg_img_t r;

    always_comb begin
        r        = reg_img_t'(reg_word);
        mem_word = {r.sign, r.exp[DEXP_W-1], r.exp[LOW_W-1:0], r.frac};
    end
endmodule

// File: rtl/lw_pack.sv
module lw_pack
    import sp_regfmt_pkg::*;
(
    input  logic [REG_W-1:0] int_word,
    output logic [REG_W-1:0] reg_word,
    output conv_flags_t      flags
);
    localparam int GAP_BITS = REG_W - MEM_W - PAD_W;

    logic [REG_W-1:0] sext;
    logic             no_fit;

    always_comb begin
        sext          = {{(REG_W-MEM_W){int_word[MEM_W-1]}}, int_word[MEM_W-1:0]};
        no_fit        = (sext != int_word);
        reg_word      = {int_word[MEM_W-1 -: LW_HI_W], {GAP_BITS{1'b0}},
                         int_word[LW_LO_W-1:0], {PAD_W{1'b0}}};
        flags.ovf     = no_fit;
        flags.inexact = no_fit;
    end
endmodule

// File: rtl/sp_regfmt_conv.sv
module sp_regfmt_conv
    import sp_regfmt_pkg::*;
(
    input  logic [1:0]       mode_sel,
    input  logic [REG_W-1:0] data_in,
    output logic [REG_W-1:0] data_out,
    output logic             ovf_flag,
    output logic             inexact_flag
);
    logic [REG_W-1:0] load_res;
    logic [MEM_W-1:0] store_res;
    logic [REG_W-1:0] pack_res;
    conv_flags_t      pack_flags;
    conv_flags_t      out_flags;
    conv_mode_e       mode;

    sp_expand u_expand (
        .mem_word (data_in[MEM_W-1:0]),
        .reg_word (load_res)
    );

    sp_compress u_compress (
        .reg_word (data_in),
        .mem_word (store_res)
    );

    lw_pack u_pack (
        .int_word (data_in),
        .reg_word (pack_res),
        .flags    (pack_flags)
    );

    always_comb begin
        mode      = conv_mode_e'(mode_sel);
        data_out  = '0;
        out_flags = '0;
        unique case (mode)
            CONV_LOAD:   data_out = load_res;
            CONV_STORE:  data_out = {{(REG_W-MEM_W){1'b0}}, store_res};
            CONV_LWPACK: begin
                data_out  = pack_res;
                out_flags = pack_flags;
            end
            default: begin
                data_out  = '0;
                out_flags = '0;
            end
        endcase
    end

    assign ovf_flag     = out_flags.ovf;
    assign inexact_flag = out_flags.inexact;
endmodule

// File: rtl/sp_regfmt_conv_chk.sv
module sp_regfmt_conv_chk
    import sp_regfmt_pkg::*;
(
    input logic [1:0]       mode_sel,
    input logic [REG_W-1:0] data_in,
    input logic [REG_W-1:0] data_out,
    input logic             ovf_flag,
    input logic             inexact_flag
);
    always_comb begin
        if (mode_sel == 2'b00) begin
            p_round_trip_r1: assert ({data_out[63:62], data_out[58:29]} == data_in[31:0])
                else $error("R1 load does not fold back to its source");
            p_low_zero_r1: assert (data_out[28:0] == '0)
                else $error("R1 low bits nonzero");
            if (data_in[30:23] == 8'hFF) begin
                p_inf_nan_r3: assert (data_out[62:52] == 11'h7FF)
                    else $error("R3 special exponent lost");
            end
            if (data_in[30:23] == 8'h00) begin
                p_zero_exp_r5: assert (data_out[62:52] == 11'h000)
                    else $error("R5 zero exponent changed");
            end
        end
        if (mode_sel == 2'b01) begin
            p_store_upper_r6: assert (data_out[63:32] == '0)
                else $error("R6 upper bits nonzero");
        end
        p_flag_pair_r8: assert (ovf_flag == inexact_flag)
            else $error("R8 flags differ");
        if (mode_sel == 2'b10 && data_in == {{32{data_in[31]}}, data_in[31:0]}) begin
            p_fit_quiet_r8: assert (!ovf_flag)
                else $error("R8 flag on fitting value");
        end
        if (mode_sel != 2'b10) begin
            p_flags_quiet_r9: assert (!ovf_flag && !inexact_flag)
                else $error("R9 flag outside pack mode");
        end
        if (mode_sel == 2'b11) begin
            p_idle_zero_r10: assert (data_out == '0)
                else $error("R10 idle output nonzero");
        end
    end
endmodule

bind sp_regfmt_conv sp_regfmt_conv_chk chk_i (
    .mode_sel     (mode_sel),
    .data_in      (data_in),
    .data_out     (data_out),
    .ovf_flag     (ovf_flag),
    .inexact_flag (inexact_flag)
);

// File: tb/sp_regfmt_conv_tb.sv
module sp_regfmt_conv_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = 2'b11;
    logic [63:0] data_in = '0;
    logic [63:0] data_out;
    logic        ovf_flag;
    logic        inexact_flag;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sp_regfmt_conv dut_i (
        .mode_sel     (mode_sel),
        .data_in      (data_in),
        .data_out     (data_out),
        .ovf_flag     (ovf_flag),
        .inexact_flag (inexact_flag)
    );

    function automatic logic [63:0] ref_load(input logic [31:0] m);
        int unsigned ev;
        logic [10:0] e;
        ev = int'(m[30:23]);
        if (ev == 0)        e = 11'd0;
        else if (ev == 255) e = 11'h7FF;
        else                e = 11'(ev + 896);
        return {m[31], e, m[22:0], 29'd0};
    endfunction

    function automatic logic [63:0] ref_store(input logic [63:0] r);
        logic [63:0] o;
        o = '0;
        o[31] = r[63];
        o[30] = r[62];
        for (int i = 0; i < 30; i++) o[i] = r[29+i];
        return o;
    endfunction

    function automatic logic [63:0] ref_pack(input logic [63:0] v);
        logic [63:0] o;
        o = '0;
        o[63] = v[31];
        o[62] = v[30];
        for (int i = 0; i < 30; i++) o[29+i] = v[i];
        return o;
    endfunction

    function automatic logic ref_nofit(input logic [63:0] v);
        longint s;
        s = longint'(v);
        return (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_vec(input logic [1:0] m, input logic [63:0] d);
        logic [63:0] exp_out;
        logic        exp_flag;
        string       rq;
        @(posedge clk);
        #1;
        mode_sel = m;
        data_in  = d;
        @(negedge clk);
        exp_flag = 1'b0;
        case (m)
            2'b00: begin exp_out = ref_load(d[31:0]); rq = "R1/R2/R3/R4/R5 load"; end
            2'b01: begin exp_out = ref_store(d);      rq = "R6 store"; end
            2'b10: begin exp_out = ref_pack(d); exp_flag = ref_nofit(d); rq = "R7 pack"; end
            default: begin exp_out = '0;             rq = "R10 idle"; end
        endcase
        check(rq, data_out, exp_out);
        check((m == 2'b10) ? "R8 overflow flag" : "R9 overflow flag", 64'(ovf_flag), 64'(exp_flag));
        check((m == 2'b10) ? "R8 inexact flag" : "R9 inexact flag", 64'(inexact_flag), 64'(exp_flag));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R10: idle state after reset gives zero and no flags
        check("R10 idle after reset", data_out, 64'd0);
        check("R9 flags after reset", {62'd0, ovf_flag, inexact_flag}, 64'd0);

        // Directed load cases, upper input bits set to show R1 ignores them
        run_vec(2'b00, 64'hDEAD_BEEF_0000_0000);        // R5 zero
        run_vec(2'b00, 64'h0000_0000_0000_0001);        // R5 denormal
        run_vec(2'b00, 64'hFFFF_FFFF_7F80_0000);        // R3 infinity
        run_vec(2'b00, 64'h0000_0000_FFC0_0001);        // R3 NaN
        run_vec(2'b00, 64'h0000_0000_3F80_0000);        // R4 exp 0x7F
        run_vec(2'b00, 64'h1234_5678_4000_0000);        // R2 exp 0x80
        run_vec(2'b00, 64'h0000_0000_7F7F_FFFF);        // R2 exp 0xFE
        run_vec(2'b00, 64'h0000_0000_0080_0000);        // R4 exp 0x01
        // Directed store and pack edges
        run_vec(2'b01, 64'hFFFF_FFFF_FFFF_FFFF);        // R6
        run_vec(2'b01, 64'h3800_0000_0000_0000);        // R6 discarded bits
        run_vec(2'b10, 64'h0000_0000_7FFF_FFFF);        // R8 max fits
        run_vec(2'b10, 64'hFFFF_FFFF_8000_0000);        // R8 min fits
        run_vec(2'b10, 64'h0000_0000_8000_0000);        // R8 2^31 overflows
        run_vec(2'b10, 64'hFFFF_FFFF_7FFF_FFFF);        // R8 below min
        run_vec(2'b10, 64'h8000_0000_0000_0000);        // R8
        run_vec(2'b11, 64'hFFFF_FFFF_FFFF_FFFF);        // R10

        for (int i = 0; i < N_RANDOM; i++) begin
            logic [1:0] m;
            m = 2'($urandom_range(0, 3));
            v = {$urandom, $urandom};
            if (m == 2'b10 && $urandom_range(0, 1) == 1)
                v[63:32] = {32{v[31]}};
            run_vec(m, v);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule